// File: doc/BRIEF.md
# Rolling-Shutter Readout Sequencer

This block is the digital timing engine for a column-parallel imager built on a rolling shutter. It owns two circular one-hot chains, one for the rows and one for the columns. For every row it runs a fixed routine:

1. Sample the pixel outputs while the first hold phase is high.
2. Swap to the second hold phase across a dead gap.
3. Walk the column chain, raising one conversion strobe per column for an external converter.
4. Swap the holds back and pulse the reset of the row just read.
5. Advance the row chain.

A frame ends once every active row has been visited. At that point each row has integrated for exactly one frame of row periods.

Binning is done by skipping. In the 2x2 and 4x4 modes both chains jump by two or four positions per advance. Skipped rows are therefore never selected and never reset. The default array of 124 rows by 132 columns reads out as 62x66 or 31x33. While the sequencer is stopped, either chain can be reloaded through a one-bit serial port, which sets the row and column where scanning starts. Clearing the run input lets the current frame finish before the block goes idle.

Top module: `imgseq_top`

## Requirements
- R1: After reset, `row_sel` and `col_sel` each hold a single 1 at bit 0, and `sample`, `hold1`, `hold2`, `row_rst` and `adc_strobe` are all low.
- R2: `hold1` and `hold2` are never high in the same cycle. Whenever `hold2` rises, `hold1` was low in the previous cycle.
- R3: `sample` is high only while `hold1` is high and `hold2` is low. Each sample pulse lasts exactly SAMPLE_CYC cycles.
- R4: In every row, `adc_strobe` fires once per active column, which is COLS, COLS/2 or COLS/4 times. The first strobe sees the column chain at its start position. Each later strobe sees it one step further on, where the step is 1, 2 or 4.
- R5: When `hold2` falls at the end of a row scan, the column chain is back at its start position.
- R6: `row_rst` is high for exactly `rst_len` consecutive cycles per row, and never when `rst_len` is 0. It is only ever high on the currently selected row, after the scan, with `hold1` high and `hold2` low. The row select does not move while it is high.
- R7: The row chain moves only on a row advance, by one step and wrapping from the top index to index 0. The column chain moves only on a strobe or a serial load.
- R8: A frame is ROWS/step rows. When `run` is cleared, the current frame completes. The block then stays idle, with no strobes, both holds low and the row chain back at its start position.
- R9: While idle, `load_en` shifts `load_bit` into bit 0 of the chain chosen by `load_sel` (0 = row, 1 = column), and the older bits move one place up. While running, `load_en` is ignored.
- R10: `bin_mode` encoding: 0 means 1x1, 1 means 2x2, and 2 or 3 mean 4x4. The mode is captured when a frame starts.
- R11: `adc_strobe` is a single-cycle pulse. It comes at least SETTLE_CYC cycles after the column chain last changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Start frames when set; stop at frame end when cleared |
| bin_mode | input | 2 | Binning selection, captured at frame start |
| rst_len | input | RST_W | Row reset length in cycles (0 disables the reset) |
| load_en | input | 1 | Serial chain load enable (idle only) |
| load_sel | input | 1 | Chain to load: 0 row, 1 column |
| load_bit | input | 1 | Serial data bit |
| row_sel | output | ROWS | One-hot row select (row chain) |
| row_rst | output | ROWS | Reset pulse for the selected row |
| col_sel | output | COLS | One-hot column select (column chain) |
| sample | output | 1 | First-phase sample pulse |
| hold1 | output | 1 | First hold phase |
| hold2 | output | 1 | Second hold phase |
| adc_strobe | output | 1 | Per-pixel conversion strobe |

## Verification
The embedded properties are checked on every cycle. They cover the exclusivity of the hold phases and the dead cycle before `hold2` rises. They cover the confinement of the sample pulse to the first phase and the single-cycle strobe with its settle distance. They also cover the rule that neither chain moves except on its own advance or on a load.

Some properties span a whole row or frame, and only the bench scenarios can show them:
- the strobe count in each binning mode, and the step between successive column positions;
- the column chain returning to its start;
- the exact reset width, including the zero case;
- the stop taking effect only at the frame boundary;
- serial loads being ignored mid-frame.

// File: rtl/imgseq_pkg.sv
package imgseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SMP,
        ST_DEAD1,
        ST_SCAN,
        ST_DEAD2,
        ST_RST,
        ST_ADV
    } seq_state_e;

    // shift amount: 0 -> step 1, 1 -> step 2, 2 -> step 4
    function automatic logic [1:0] bin_shift(input logic [1:0] mode);
        case (mode)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/imgseq_ring.sv
module imgseq_ring #(
    parameter int N = 124
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_en,
    input  logic         ld_bit,
    input  logic         adv,
    input  logic [1:0]   shamt,
    output logic [N-1:0] q
);

    logic [N-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (ld_en) begin
            chain_d = {chain_q[N-2:0], ld_bit};
        end else if (adv) begin
            case (shamt)
                2'd0:    chain_d = {chain_q[N-2:0], chain_q[N-1]};
                2'd1:    chain_d = {chain_q[N-3:0], chain_q[N-1:N-2]};
                default: chain_d = {chain_q[N-5:0], chain_q[N-1:N-4]};
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= N'(1);
        else        chain_q <= chain_d;
    end

    assign q = chain_q;

endmodule

// File: rtl/imgseq_ctrl.sv
module imgseq_ctrl
    import imgseq_pkg::*;
#(
    parameter int ROWS       = 124,
    parameter int COLS       = 132,
    parameter int SAMPLE_CYC = 2,
    parameter int GAP_CYC    = 1,
    parameter int SETTLE_CYC = 2,
    parameter int RST_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       bin_mode,
    input  logic [RST_W-1:0] rst_len,
    output logic             row_adv,
    output logic             col_adv,
    output logic [1:0]       shamt,
    output logic             sample,
    output logic             hold1,
    output logic             hold2,
    output logic             rst_on,
    output logic             strobe,
    output logic             idle
);

    localparam int M1    = (SAMPLE_CYC > GAP_CYC) ? SAMPLE_CYC : GAP_CYC;
    localparam int M2    = (M1 > SETTLE_CYC) ? M1 : SETTLE_CYC;
    localparam int CMAX  = (M2 > (1 << RST_W)) ? M2 : (1 << RST_W);
    localparam int CNT_W = $clog2(CMAX + 1);
    localparam int CI_W  = $clog2(COLS);
    localparam int RI_W  = $clog2(ROWS);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [CI_W-1:0]  col_idx;
        logic [RI_W-1:0]  row_idx;
        logic [1:0]       shamt;
    } ctrl_s;

    ctrl_s s_d, s_q;
    logic [CI_W-1:0]  col_last;
    logic [RI_W-1:0]  row_last;
    logic [CNT_W-1:0] rst_lim;

    always_comb begin
        case (s_q.shamt)
            2'd0: begin
                col_last = CI_W'(COLS - 1);
                row_last = RI_W'(ROWS - 1);
            end
            2'd1: begin
                col_last = CI_W'(COLS / 2 - 1);
                row_last = RI_W'(ROWS / 2 - 1);
            end
            default: begin
                col_last = CI_W'(COLS / 4 - 1);
                row_last = RI_W'(ROWS / 4 - 1);
            end
        endcase
        rst_lim = CNT_W'(rst_len) - CNT_W'(1);
    end

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (run) begin
                    s_d.shamt   = bin_shift(bin_mode);
                    s_d.row_idx = '0;
                    s_d.cnt     = '0;
                    s_d.st      = ST_PRE;
                end
            end
            ST_PRE: begin
                if (s_q.cnt == CNT_W'(GAP_CYC - 1)) begin
                    s_d.cnt = '0;
                    s_d.st  = ST_SMP;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_SMP: begin
                if (s_q.cnt == CNT_W'(SAMPLE_CYC - 1)) begin
                    s_d.cnt = '0;
                    s_d.st  = ST_DEAD1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_DEAD1: begin
                if (s_q.cnt == CNT_W'(GAP_CYC - 1)) begin
                    s_d.cnt     = '0;
                    s_d.col_idx = '0;
                    s_d.st      = ST_SCAN;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_SCAN: begin
                if (s_q.cnt == CNT_W'(SETTLE_CYC)) begin
                    s_d.cnt = '0;
                    if (s_q.col_idx == col_last) s_d.st = ST_DEAD2;
                    else s_d.col_idx = s_q.col_idx + 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_DEAD2: begin
                if (s_q.cnt == CNT_W'(GAP_CYC - 1)) begin
                    s_d.cnt = '0;
                    s_d.st  = (rst_len == '0) ? ST_ADV : ST_RST;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_RST: begin
                if (s_q.cnt == rst_lim) begin
                    s_d.cnt = '0;
                    s_d.st  = ST_ADV;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_ADV: begin
                s_d.cnt = '0;
                if (s_q.row_idx == row_last) begin
                    s_d.row_idx = '0;
                    if (run) begin
                        s_d.shamt = bin_shift(bin_mode);
                        s_d.st    = ST_PRE;
                    end else begin
                        s_d.st = ST_IDLE;
                    end
                end else begin
                    s_d.row_idx = s_q.row_idx + 1'b1;
                    s_d.st      = ST_PRE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st      <= ST_IDLE;
            s_q.cnt     <= '0;
            s_q.col_idx <= '0;
            s_q.row_idx <= '0;
            s_q.shamt   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hold1   = (s_q.st == ST_PRE) || (s_q.st == ST_SMP) ||
                     (s_q.st == ST_RST) || (s_q.st == ST_ADV);
    assign hold2   = (s_q.st == ST_SCAN);
    assign sample  = (s_q.st == ST_SMP);
    assign rst_on  = (s_q.st == ST_RST);
    assign strobe  = (s_q.st == ST_SCAN) && (s_q.cnt == CNT_W'(SETTLE_CYC));
    assign col_adv = strobe;
    assign row_adv = (s_q.st == ST_ADV);
    assign idle    = (s_q.st == ST_IDLE);
    assign shamt   = s_q.shamt;

    a_r2_hold_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold1 && hold2));

    a_r2_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold2) |-> !$past(hold1));

    a_r3_sample_phase: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> (hold1 && !hold2));

    a_r11_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

endmodule

// File: rtl/imgseq_top.sv
module imgseq_top
    import imgseq_pkg::*;
#(
    parameter int ROWS       = 124,
    parameter int COLS       = 132,
    parameter int SAMPLE_CYC = 2,
    parameter int GAP_CYC    = 1,
    parameter int SETTLE_CYC = 2,
    parameter int RST_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       bin_mode,
    input  logic [RST_W-1:0] rst_len,
    input  logic             load_en,
    input  logic             load_sel,
    input  logic             load_bit,
    output logic [ROWS-1:0]  row_sel,
    output logic [ROWS-1:0]  row_rst,
    output logic [COLS-1:0]  col_sel,
    output logic             sample,
    output logic             hold1,
    output logic             hold2,
    output logic             adc_strobe
);

    localparam int SINCE_W = $clog2(SETTLE_CYC + 2);

    logic       row_adv, col_adv, rst_on, idle;
    logic [1:0] shamt;
    logic       ld_row, ld_col;

    assign ld_row = load_en && idle && !load_sel;
    assign ld_col = load_en && idle &&  load_sel;

    imgseq_ctrl #(
        .ROWS(ROWS), .COLS(COLS), .SAMPLE_CYC(SAMPLE_CYC),
        .GAP_CYC(GAP_CYC), .SETTLE_CYC(SETTLE_CYC), .RST_W(RST_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .run(run), .bin_mode(bin_mode),
        .rst_len(rst_len), .row_adv(row_adv), .col_adv(col_adv),
        .shamt(shamt), .sample(sample), .hold1(hold1), .hold2(hold2),
        .rst_on(rst_on), .strobe(adc_strobe), .idle(idle)
    );

    imgseq_ring #(.N(ROWS)) u_row_ring (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_row), .ld_bit(load_bit),
        .adv(row_adv), .shamt(shamt), .q(row_sel)
    );

    imgseq_ring #(.N(COLS)) u_col_ring (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_col), .ld_bit(load_bit),
        .adv(col_adv), .shamt(shamt), .q(col_sel)
    );

    assign row_rst = rst_on ? row_sel : '0;

    // cycles since the column chain last moved, saturating
    logic [SINCE_W-1:0] since_d, since_q;

    always_comb begin
        if (col_adv || ld_col)
            since_d = '0;
        else if (since_q != SINCE_W'(SETTLE_CYC + 1))
            since_d = since_q + 1'b1;
        else
            since_d = since_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_q <= SINCE_W'(SETTLE_CYC + 1);
        else        since_q <= since_d;
    end

    a_r11_settle: assert property (@(posedge clk) disable iff (!rst_n)
        adc_strobe |-> (since_q >= SINCE_W'(SETTLE_CYC)));

    a_r7_row_still: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(row_adv) && !$past(ld_row)) |-> $stable(row_sel));

    a_r7_col_still: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(col_adv) && !$past(ld_col)) |-> $stable(col_sel));

    a_r6_row_held_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(row_rst != '0) && (row_rst != '0)) |-> $stable(row_sel));

endmodule

// File: tb/imgseq_top_bench.sv
`timescale 1ns/1ps
module imgseq_top_bench;

    localparam int BR  = 8;
    localparam int BC  = 12;
    localparam int SMP = 2;
    localparam int GAP = 1;
    localparam int STL = 2;
    localparam int RW  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic [1:0]    bin_mode = 2'd0;
    logic [RW-1:0] rst_len = '0;
    logic          load_en = 1'b0, load_sel = 1'b0, load_bit = 1'b0;
    logic [BR-1:0] row_sel, row_rst;
    logic [BC-1:0] col_sel;
    logic          sample, hold1, hold2, adc_strobe;

    always #2.5 clk = ~clk;

    imgseq_top #(
        .ROWS(BR), .COLS(BC), .SAMPLE_CYC(SMP), .GAP_CYC(GAP),
        .SETTLE_CYC(STL), .RST_W(RW)
    ) u_imgseq_top (
        .clk(clk), .rst_n(rst_n), .run(run), .bin_mode(bin_mode),
        .rst_len(rst_len), .load_en(load_en), .load_sel(load_sel),
        .load_bit(load_bit), .row_sel(row_sel), .row_rst(row_rst),
        .col_sel(col_sel), .sample(sample), .hold1(hold1), .hold2(hold2),
        .adc_strobe(adc_strobe)
    );

    int total = 0, bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int oh_pos(input logic [31:0] v);
        if ($countones(v) != 1) return -1;
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic int step_of(input logic [1:0] m);
        return (m == 2'd0) ? 1 : (m == 2'd1) ? 2 : 4;
    endfunction

    // reference model state
    int  step = 1, rlen = 0;
    int  exp_row = 0, exp_col = 0, col_start = 0;
    int  nstb = 0, total_stb = 0, rows_done = 0;
    int  smp_w = 0, rst_w = 0;
    bit  mon_on = 0, loading = 0;
    logic [BR-1:0] p_row;
    logic p_h1, p_h2, p_smp, p_stb, p_rrst;

    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (hold1 || hold2) chk(!(hold1 && hold2), "R2 overlap", {hold1, hold2}, 0);
            if (hold2 && !p_h2) chk(!p_h1, "R2 gap", p_h1, 0);
            if (sample) begin
                chk(hold1 && !hold2, "R3 phase", {hold1, hold2}, 2);
                smp_w++;
            end else if (p_smp) begin
                chk(smp_w == SMP, "R3 width", smp_w, SMP);
                smp_w = 0;
            end
            if (adc_strobe) begin
                chk(!p_stb, "R11 single", p_stb, 0);
                chk(oh_pos(32'(col_sel)) == exp_col, "R4 column", oh_pos(32'(col_sel)), exp_col);
                chk(oh_pos(32'(row_sel)) == exp_row, "R7 row at strobe", oh_pos(32'(row_sel)), exp_row);
                exp_col = (exp_col + step) % BC;
                nstb++;
                total_stb++;
            end
            if (p_h2 && !hold2) begin
                chk(nstb == BC / step, "R4/R10 strobe count", nstb, BC / step);
                chk(oh_pos(32'(col_sel)) == col_start, "R5 column return", oh_pos(32'(col_sel)), col_start);
                nstb = 0;
                rows_done++;
            end
            if (row_rst != '0) begin
                chk(rlen != 0 && oh_pos(32'(row_rst)) == exp_row && hold1 && !hold2,
                    "R6 reset place", oh_pos(32'(row_rst)), exp_row);
                rst_w++;
            end else if (p_rrst) begin
                chk(rst_w == rlen, "R6 reset width", rst_w, rlen);
                rst_w = 0;
            end
            if (row_sel != p_row && !loading) begin
                chk(oh_pos(32'(row_sel)) == (exp_row + step) % BR, "R7 row advance",
                    oh_pos(32'(row_sel)), (exp_row + step) % BR);
                exp_row = (exp_row + step) % BR;
            end
        end
        p_row  = row_sel;
        p_h1   = hold1;
        p_h2   = hold2;
        p_smp  = sample;
        p_stb  = adc_strobe;
        p_rrst = (row_rst != '0);
    end

    task automatic load_chain(input bit sel, input int pos);
        int n;
        n = sel ? BC : BR;
        loading = 1;
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            load_en  = 1'b1;
            load_sel = sel;
            load_bit = (i == pos);
        end
        @(negedge clk);
        load_en = 1'b0;
        if (sel) begin
            chk(oh_pos(32'(col_sel)) == pos, "R9 column load", oh_pos(32'(col_sel)), pos);
            exp_col = pos;
        end else begin
            chk(oh_pos(32'(row_sel)) == pos, "R9 row load", oh_pos(32'(row_sel)), pos);
            exp_row = pos;
        end
        @(negedge clk);
        loading = 0;
    endtask

    task automatic run_frames(input logic [1:0] m, input int rl, input int nf, input bit poke);
        int base, rpf, start_row, snap;
        @(negedge clk);
        bin_mode  = m;
        rst_len   = RW'(rl);
        step      = step_of(m);
        rlen      = rl;
        start_row = exp_row;
        col_start = exp_col;
        base      = rows_done;
        rpf       = BR / step;
        run       = 1'b1;
        while (rows_done < base + (nf - 1) * rpf + 1) @(negedge clk);
        if (poke) begin
            // R9: loads during a frame must be ignored
            for (int k = 0; k < 3; k++) begin
                load_en  = 1'b1;
                load_bit = 1'b1;
                load_sel = k[0];
                @(negedge clk);
            end
            load_en = 1'b0;
        end
        run = 1'b0;
        while (rows_done < base + nf * rpf) @(negedge clk);
        repeat (30) @(negedge clk);
        chk(rows_done == base + nf * rpf, "R8 rows per frame", rows_done - base, nf * rpf);
        chk(oh_pos(32'(row_sel)) == start_row, "R8 row chain home", oh_pos(32'(row_sel)), start_row);
        chk(!hold1 && !hold2, "R8 idle holds", {hold1, hold2}, 0);
        snap = total_stb;
        repeat (40) @(negedge clk);
        chk(total_stb == snap, "R8 no strobes when idle", total_stb - snap, 0);
        chk(oh_pos(32'(col_sel)) == col_start, "R9 column chain kept", oh_pos(32'(col_sel)), col_start);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(row_sel == BR'(1), "R1 row chain", int'(row_sel), 1);
        chk(col_sel == BC'(1), "R1 column chain", int'(col_sel), 1);
        chk({sample, hold1, hold2, adc_strobe} == 4'b0, "R1 controls",
            int'({sample, hold1, hold2, adc_strobe}), 0);
        chk(row_rst == '0, "R1 row reset", int'(row_rst), 0);
        mon_on = 1;

        run_frames(2'd0, 3, 1, 0);
        run_frames(2'd1, 0, 1, 0);
        run_frames(2'd2, 2, 1, 0);
        run_frames(2'd3, 1, 1, 0);          // R10 code 3 behaves as 4x4
        load_chain(1'b0, 3);
        load_chain(1'b1, 5);
        run_frames(2'd0, 2, 2, 1);
        load_chain(1'b0, 6);
        run_frames(2'd1, 4, 1, 1);

        for (int it = 0; it < 6; it++) begin
            logic [1:0] m;
            int rl, nf, rp, cp, st;
            m  = 2'($urandom % 4);
            rl = $urandom % 6;
            nf = 1 + $urandom % 2;
            st = step_of(m);
            rp = ($urandom % (BR / st)) * st;
            cp = ($urandom % (BC / st)) * st;
            if ($urandom % 2) load_chain(1'b0, rp);
            if ($urandom % 2) load_chain(1'b1, cp);
            run_frames(m, rl, nf, bit'($urandom % 2));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule